// File: doc/BRIEF.md
# Buffer Descriptor Ring Manager

This block holds the descriptor table that a MAC's frame engines walk to find buffers to send and buffers to fill. One shared table of `NUM_BD` eight-byte descriptors sits on a 32-bit register bus. Each descriptor has a status/control word and a buffer address word. A programmable count splits the table. The leading descriptors form the transmit ring and the rest form the receive ring.

Each ring has its own hardware pointer. A descriptor is handed to its frame side only while software has marked it as owned by hardware. For transmit that is the ready bit, and for receive it is the empty bit. When the frame side reports completion, the block returns ownership to software and writes back the length and result bits. It then raises a one-cycle event and advances the pointer. The pointer goes back to the first descriptor of its ring after a descriptor with the wrap bit set, or after the ring's last descriptor. A receive frame that finds no empty descriptor is dropped and signalled as busy.

Top module: `bd_ring_mgr`

## Requirements
- R1: After reset, both ring enables are clear and the transmit count reads `NUM_BD/2`. `tx_req_o`, `rx_avail_o` and all event outputs are low.
- R2: The status word of descriptor i is at byte address 0x400+8*i and its buffer address is at 0x400+8*i+4. Both are readable and writable. Read data appears on `bus_rdata_o` in the cycle after the request.
- R3: The transmit count is at address 0x20. A written value above `NUM_BD` (0x80 with default parameters) is stored as `NUM_BD`. Reading returns the stored value. Any write to this register returns both ring pointers to the first descriptor of their rings.
- R4: The control register is at address 0x00. Bit 0 enables the receive ring and bit 1 enables the transmit ring. While an enable is clear, that ring's pointer stays at the ring's first descriptor.
- R5: `tx_req_o` is high exactly when transmit is enabled, the count is nonzero and the current descriptor has status bit 15 (ready) set. `tx_len_o` comes from status bits 31:16, `tx_pad_o` from bit 12, `tx_crc_o` from bit 11, and `tx_buf_addr_o` from the address word.
- R6: On transmit completion, the status word keeps bits 31:16 and 14:9, clears bit 15, and takes `tx_res_i` into bits 8:0 (bit 8 underrun, bits 7:4 retry count, bit 3 retry limit, bit 2 late collision, bit 1 defer, bit 0 carrier lost).
- R7: After each transmit completion the pointer moves to the next descriptor. If the completed descriptor had bit 13 (wrap) set, or was descriptor count-1, the pointer returns to descriptor 0.
- R8: If status bit 14 of the completed transmit descriptor is set, the cycle after completion pulses `evt_tx_err_o` when any of result bits 8, 3, 2, 1, 0 is set, and pulses `evt_tx_frame_o` otherwise. If bit 14 is clear, no event is raised.
- R9: `rx_avail_o` is high exactly when receive is enabled, the receive ring is non-empty (count < `NUM_BD`) and the current descriptor has bit 15 (empty) set. `rx_buf_addr_o` is that descriptor's address word.
- R10: On receive completion, the status word takes `rx_len_i` (frame length including the 4 CRC bytes) into bits 31:16, clears bit 15, keeps bits 14:9, and takes `rx_res_i` into bits 8:0 (bit 8 control frame, 7 miss, 6 overrun, 5 invalid symbol, 4 dribble nibble, 3 too long, 2 short, 1 CRC error, 0 late collision).
- R11: The receive ring starts at descriptor index equal to the count. After bit 13 (wrap), or after descriptor `NUM_BD-1`, the pointer returns to that first descriptor.
- R12: If status bit 14 of the completed receive descriptor is set, the next cycle pulses `evt_rx_err_o` when any of result bits 7:0 is set, and pulses `evt_rx_frame_o` otherwise. A control frame alone is not an error.
- R13: `rx_done_i` with receive enabled but no available descriptor pulses `evt_busy_o`. In that case the table and the pointer are unchanged. `rx_done_i` while receive is disabled has no effect and raises no event.
- R14: `tx_done_i` while `tx_req_o` is low has no effect on the table, the pointer or the events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register bus access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read |
| tx_req_o | output | 1 | A ready transmit descriptor is offered |
| tx_len_o | output | 16 | Length of the offered frame |
| tx_buf_addr_o | output | 32 | Buffer address of the offered frame |
| tx_pad_o | output | 1 | Pad short frame |
| tx_crc_o | output | 1 | Append CRC |
| tx_done_i | input | 1 | Transmit of the offered descriptor is complete |
| tx_res_i | input | 9 | Transmit result bits |
| rx_avail_o | output | 1 | An empty receive descriptor is available |
| rx_buf_addr_o | output | 32 | Buffer address for the next received frame |
| rx_done_i | input | 1 | A received frame is complete |
| rx_len_i | input | 16 | Received length including CRC |
| rx_res_i | input | 9 | Receive result bits |
| evt_tx_frame_o | output | 1 | Transmit completed without error |
| evt_tx_err_o | output | 1 | Transmit completed with error |
| evt_rx_frame_o | output | 1 | Receive completed without error |
| evt_rx_err_o | output | 1 | Receive completed with error |
| evt_busy_o | output | 1 | Receive frame dropped, no empty descriptor |

## Verification
The bench sweeps every transmit count of an eight-descriptor table, with and without a mid-ring wrap bit. It walks each ring more than twice around, so a pointer that ignored the wrap bit, or that ran past the last descriptor of its ring into the other ring, would show up as a wrong buffer address. It also covers the empty receive ring at full transmit count, where a design that indexed past the table would offer a bogus descriptor. Result patterns with only the retry count or only the control-frame bit set catch an error classification that is too broad. Descriptors with the interrupt bit clear catch events that fire without being requested. A frame that meets a non-empty descriptor must leave the pointer in place, otherwise the next buffer address is wrong. Completions while a ring is disabled, or while no descriptor is offered, must change no word of the table.

// File: rtl/bd_ring_pkg.sv
package bd_ring_pkg;
  localparam int BD_OWN_BIT  = 15;
  localparam int BD_IRQ_BIT  = 14;
  localparam int BD_WRAP_BIT = 13;
  localparam int BD_PAD_BIT  = 12;
  localparam int BD_CRC_BIT  = 11;
  localparam int RES_W       = 9;
  localparam int LEN_W       = 16;
  localparam logic [RES_W-1:0] TX_ERR_MASK = 9'h10F;
  localparam logic [RES_W-1:0] RX_ERR_MASK = 9'h0FF;
  localparam int REG_CTRL    = 'h00;
  localparam int REG_TXCNT   = 'h20;
  localparam int TBL_BASE    = 'h400;
  typedef logic [31:0]      word_t;
  typedef logic [RES_W-1:0] res_t;
endpackage

// File: rtl/bd_regs.sv
module bd_regs
  import bd_ring_pkg::*;
#(
  parameter int NUM_BD = 128,
  parameter int ADDR_W = 12,
  parameter int CNT_W  = $clog2(NUM_BD + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  word_t             wdata_i,
  output word_t             rdata_o,
  output logic              tx_en_o,
  output logic              rx_en_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              cnt_wr_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NUM_BD);
  localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(NUM_BD / 2);

  logic ctrl_wr;
  logic [CNT_W-1:0] cnt_q;
  logic tx_en_q, rx_en_q;

  assign ctrl_wr  = wr_i && (addr_i == ADDR_W'(REG_CTRL));
  assign cnt_wr_o = wr_i && (addr_i == ADDR_W'(REG_TXCNT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_en_q <= 1'b0;
      rx_en_q <= 1'b0;
      cnt_q   <= CNT_RST;
    end else begin
      if (ctrl_wr) begin
        rx_en_q <= wdata_i[0];
        tx_en_q <= wdata_i[1];
      end
      if (cnt_wr_o)
        cnt_q <= (wdata_i > 32'(NUM_BD)) ? CNT_MAX : wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(REG_CTRL))       rdata_o = {30'd0, tx_en_q, rx_en_q};
    else if (addr_i == ADDR_W'(REG_TXCNT)) rdata_o = 32'(cnt_q);
  end

  assign tx_en_o = tx_en_q;
  assign rx_en_o = rx_en_q;
  assign cnt_o   = cnt_q;

  a_r3_cnt_saturated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
  a_r3_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_wr_o |=> $stable(cnt_q));
endmodule

// File: rtl/bd_table.sv
module bd_table
  import bd_ring_pkg::*;
#(
  parameter int NUM_BD = 128,
  parameter int IDX_W  = $clog2(NUM_BD)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_wr_i,
  input  logic [IDX_W-1:0] bus_idx_i,
  input  logic             bus_hi_i,
  input  word_t            bus_wdata_i,
  output word_t            bus_rdata_o,
  input  logic [IDX_W-1:0] tx_idx_i,
  output logic [31:9]      tx_stat_o,
  output word_t            tx_addr_o,
  input  logic             tx_wb_i,
  input  word_t            tx_wb_data_i,
  input  logic [IDX_W-1:0] rx_idx_i,
  output logic [15:0]      rx_stat_o,
  output word_t            rx_addr_o,
  input  logic             rx_wb_i,
  input  word_t            rx_wb_data_i
);
  word_t stat_q [NUM_BD];
  word_t addr_q [NUM_BD];

  // hardware writeback is applied last and wins over a same-cycle bus write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_BD; i++) begin
        stat_q[i] <= '0;
        addr_q[i] <= '0;
      end
    end else begin
      if (bus_wr_i && !bus_hi_i) stat_q[bus_idx_i] <= bus_wdata_i;
      if (bus_wr_i &&  bus_hi_i) addr_q[bus_idx_i] <= bus_wdata_i;
      if (tx_wb_i) stat_q[tx_idx_i] <= tx_wb_data_i;
      if (rx_wb_i) stat_q[rx_idx_i] <= rx_wb_data_i;
    end
  end

  assign bus_rdata_o = bus_hi_i ? addr_q[bus_idx_i] : stat_q[bus_idx_i];
  assign tx_stat_o   = stat_q[tx_idx_i][31:9];
  assign tx_addr_o   = addr_q[tx_idx_i];
  assign rx_stat_o   = stat_q[rx_idx_i][15:0];
  assign rx_addr_o   = addr_q[rx_idx_i];
endmodule

// File: rtl/bd_tx_walk.sv
module bd_tx_walk
  import bd_ring_pkg::*;
#(
  parameter int NUM_BD = 128,
  parameter int IDX_W  = $clog2(NUM_BD),
  parameter int CNT_W  = $clog2(NUM_BD + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             restart_i,
  input  logic [31:9]      cur_stat_i,
  input  word_t            cur_addr_i,
  input  logic             done_i,
  input  res_t             res_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             req_o,
  output logic [LEN_W-1:0] len_o,
  output word_t            addr_o,
  output logic             pad_o,
  output logic             crc_o,
  output logic             wb_o,
  output word_t            wb_data_o,
  output logic             evt_frame_o,
  output logic             evt_err_o
);
  logic [IDX_W-1:0] ptr_q;
  logic fire, last, irq, err;
  logic evt_frame_q, evt_err_q;

  assign req_o  = en_i && (cnt_i != '0) && cur_stat_i[BD_OWN_BIT];
  assign fire   = req_o && done_i;
  assign last   = CNT_W'(ptr_q) == (cnt_i - 1'b1);
  assign irq    = cur_stat_i[BD_IRQ_BIT];
  assign err    = |(res_i & TX_ERR_MASK);
  assign idx_o  = ptr_q;
  assign len_o  = cur_stat_i[31:16];
  assign addr_o = cur_addr_i;
  assign pad_o  = cur_stat_i[BD_PAD_BIT];
  assign crc_o  = cur_stat_i[BD_CRC_BIT];
  assign wb_o   = fire;
  assign wb_data_o = {cur_stat_i[31:16], 1'b0, cur_stat_i[14:9], res_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q       <= '0;
      evt_frame_q <= 1'b0;
      evt_err_q   <= 1'b0;
    end else begin
      evt_frame_q <= fire && irq && !err;
      evt_err_q   <= fire && irq && err;
      if (!en_i || restart_i)
        ptr_q <= '0;
      else if (fire)
        ptr_q <= (cur_stat_i[BD_WRAP_BIT] || last) ? '0 : ptr_q + 1'b1;
    end
  end

  assign evt_frame_o = evt_frame_q;
  assign evt_err_o   = evt_err_q;

  a_r7_ptr_in_ring: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_i != '0) |-> (CNT_W'(ptr_q) < cnt_i));
  a_r7_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !restart_i && !cur_stat_i[BD_WRAP_BIT] && !last) |=> (ptr_q == $past(ptr_q) + 1'b1));
  a_r4_tx_home: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (ptr_q == '0));
  a_r8_tx_evt_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(evt_frame_q && evt_err_q));
  a_r14_idle_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !req_o && en_i && !restart_i) |=> ($stable(ptr_q) && !evt_frame_q && !evt_err_q));
endmodule

// File: rtl/bd_rx_walk.sv
module bd_rx_walk
  import bd_ring_pkg::*;
#(
  parameter int NUM_BD = 128,
  parameter int IDX_W  = $clog2(NUM_BD),
  parameter int CNT_W  = $clog2(NUM_BD + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] base_i,
  input  logic             restart_i,
  input  logic [15:0]      cur_stat_i,
  input  word_t            cur_addr_i,
  input  logic             done_i,
  input  logic [LEN_W-1:0] len_i,
  input  res_t             res_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             avail_o,
  output word_t            addr_o,
  output logic             wb_o,
  output word_t            wb_data_o,
  output logic             evt_frame_o,
  output logic             evt_err_o,
  output logic             evt_busy_o
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_BD - 1);
  localparam logic [CNT_W-1:0] NUM_C    = CNT_W'(NUM_BD);

  logic [CNT_W-1:0] off_q, abs_idx;
  logic ring_ok, fire, miss, last, irq, err;
  logic evt_frame_q, evt_err_q, evt_busy_q;

  assign abs_idx = base_i + off_q;
  assign ring_ok = base_i < NUM_C;
  assign idx_o   = abs_idx[IDX_W-1:0];
  assign avail_o = en_i && ring_ok && cur_stat_i[BD_OWN_BIT];
  assign fire    = done_i && avail_o;
  assign miss    = done_i && en_i && !avail_o;
  assign last    = abs_idx == LAST_IDX;
  assign irq     = cur_stat_i[BD_IRQ_BIT];
  assign err     = |(res_i & RX_ERR_MASK);
  assign addr_o  = cur_addr_i;
  assign wb_o    = fire;
  assign wb_data_o = {len_i, 1'b0, cur_stat_i[14:9], res_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q       <= '0;
      evt_frame_q <= 1'b0;
      evt_err_q   <= 1'b0;
      evt_busy_q  <= 1'b0;
    end else begin
      evt_frame_q <= fire && irq && !err;
      evt_err_q   <= fire && irq && err;
      evt_busy_q  <= miss;
      if (!en_i || restart_i)
        off_q <= '0;
      else if (fire)
        off_q <= (cur_stat_i[BD_WRAP_BIT] || last) ? '0 : off_q + 1'b1;
    end
  end

  assign evt_frame_o = evt_frame_q;
  assign evt_err_o   = evt_err_q;
  assign evt_busy_o  = evt_busy_q;

  a_r11_ptr_in_ring: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ring_ok |-> (abs_idx < NUM_C));
  a_r13_miss_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss && !restart_i) |=> $stable(off_q));
  a_r13_busy_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(evt_busy_q && (evt_frame_q || evt_err_q)));
  a_r12_rx_evt_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(evt_frame_q && evt_err_q));
  a_r4_rx_home: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (off_q == '0));
endmodule

// File: rtl/bd_ring_mgr.sv
module bd_ring_mgr
  import bd_ring_pkg::*;
#(
  parameter int NUM_BD = 128,
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              tx_req_o,
  output logic [15:0]       tx_len_o,
  output logic [31:0]       tx_buf_addr_o,
  output logic              tx_pad_o,
  output logic              tx_crc_o,
  input  logic              tx_done_i,
  input  logic [8:0]        tx_res_i,
  output logic              rx_avail_o,
  output logic [31:0]       rx_buf_addr_o,
  input  logic              rx_done_i,
  input  logic [15:0]       rx_len_i,
  input  logic [8:0]        rx_res_i,
  output logic              evt_tx_frame_o,
  output logic              evt_tx_err_o,
  output logic              evt_rx_frame_o,
  output logic              evt_rx_err_o,
  output logic              evt_busy_o
);
  localparam int IDX_W   = $clog2(NUM_BD);
  localparam int CNT_W   = $clog2(NUM_BD + 1);
  localparam int TBL_END = TBL_BASE + NUM_BD * 8;

  logic tbl_hit, bus_wr, tbl_wr, reg_wr;
  word_t tbl_rdata, reg_rdata, rdata_q;
  logic tx_en, rx_en, cnt_wr;
  logic [CNT_W-1:0] tx_cnt;
  logic [IDX_W-1:0] tx_idx, rx_idx;
  logic [31:9] tx_stat;
  logic [15:0] rx_stat;
  word_t tx_addr, rx_addr, tx_wb_data, rx_wb_data;
  logic tx_wb, rx_wb;

  assign tbl_hit = (bus_addr_i >= ADDR_W'(TBL_BASE)) && (32'(bus_addr_i) < 32'(TBL_END));
  assign bus_wr  = bus_req_i && bus_we_i;
  assign tbl_wr  = bus_wr && tbl_hit;
  assign reg_wr  = bus_wr && !tbl_hit;

  bd_regs #(.NUM_BD(NUM_BD), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .rdata_o(reg_rdata),
    .tx_en_o(tx_en), .rx_en_o(rx_en), .cnt_o(tx_cnt), .cnt_wr_o(cnt_wr)
  );

  bd_table #(.NUM_BD(NUM_BD), .IDX_W(IDX_W)) i_table (
    .clk_i, .rst_ni,
    .bus_wr_i(tbl_wr), .bus_idx_i(bus_addr_i[IDX_W+2:3]), .bus_hi_i(bus_addr_i[2]),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(tbl_rdata),
    .tx_idx_i(tx_idx), .tx_stat_o(tx_stat), .tx_addr_o(tx_addr),
    .tx_wb_i(tx_wb), .tx_wb_data_i(tx_wb_data),
    .rx_idx_i(rx_idx), .rx_stat_o(rx_stat), .rx_addr_o(rx_addr),
    .rx_wb_i(rx_wb), .rx_wb_data_i(rx_wb_data)
  );

  bd_tx_walk #(.NUM_BD(NUM_BD), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_tx_walk (
    .clk_i, .rst_ni,
    .en_i(tx_en), .cnt_i(tx_cnt), .restart_i(cnt_wr),
    .cur_stat_i(tx_stat), .cur_addr_i(tx_addr),
    .done_i(tx_done_i), .res_i(tx_res_i),
    .idx_o(tx_idx), .req_o(tx_req_o), .len_o(tx_len_o), .addr_o(tx_buf_addr_o),
    .pad_o(tx_pad_o), .crc_o(tx_crc_o), .wb_o(tx_wb), .wb_data_o(tx_wb_data),
    .evt_frame_o(evt_tx_frame_o), .evt_err_o(evt_tx_err_o)
  );

  bd_rx_walk #(.NUM_BD(NUM_BD), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_rx_walk (
    .clk_i, .rst_ni,
    .en_i(rx_en), .base_i(tx_cnt), .restart_i(cnt_wr),
    .cur_stat_i(rx_stat), .cur_addr_i(rx_addr),
    .done_i(rx_done_i), .len_i(rx_len_i), .res_i(rx_res_i),
    .idx_o(rx_idx), .avail_o(rx_avail_o), .addr_o(rx_buf_addr_o),
    .wb_o(rx_wb), .wb_data_o(rx_wb_data),
    .evt_frame_o(evt_rx_frame_o), .evt_err_o(evt_rx_err_o), .evt_busy_o(evt_busy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    rdata_q <= '0;
    else if (bus_req_i && !bus_we_i) rdata_q <= tbl_hit ? tbl_rdata : reg_rdata;
  end
  assign bus_rdata_o = rdata_q;

  a_r13_rx_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && !rx_en) |=> !(evt_busy_o || evt_rx_frame_o || evt_rx_err_o));
  a_r9_avail_needs_ring: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_avail_o |-> (tx_cnt < CNT_W'(NUM_BD)));
endmodule

// File: tb/test_bd_ring_mgr.sv
`timescale 1ns/1ps
module test_bd_ring_mgr;
  localparam int NBD = 8;
  localparam logic [31:0] OWN = 32'h8000, IRQ = 32'h4000, WRP = 32'h2000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_ni, bus_req, bus_we, tx_done, rx_done;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata, tx_buf_addr, rx_buf_addr;
  logic tx_req, tx_pad, tx_crc, rx_avail;
  logic [15:0] tx_len, rx_len;
  logic [8:0] tx_res, rx_res;
  logic e_txf, e_txe, e_rxf, e_rxe, e_busy;

  bd_ring_mgr #(.NUM_BD(NBD)) i_bd_ring_mgr (
    .clk_i(clk), .rst_ni(rst_ni),
    .bus_req_i(bus_req), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .tx_req_o(tx_req), .tx_len_o(tx_len), .tx_buf_addr_o(tx_buf_addr),
    .tx_pad_o(tx_pad), .tx_crc_o(tx_crc), .tx_done_i(tx_done), .tx_res_i(tx_res),
    .rx_avail_o(rx_avail), .rx_buf_addr_o(rx_buf_addr), .rx_done_i(rx_done),
    .rx_len_i(rx_len), .rx_res_i(rx_res),
    .evt_tx_frame_o(e_txf), .evt_tx_err_o(e_txe), .evt_rx_frame_o(e_rxf),
    .evt_rx_err_o(e_rxe), .evt_busy_o(e_busy)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  logic [31:0] m_stat [NBD];
  logic [31:0] m_addr [NBD];
  int tx_p, rx_o, cur_cnt, step_k;

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input int a, input logic [31:0] d);
    bus_req = 1; bus_we = 1; bus_addr = 12'(a); bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic bus_rd(input int a, output logic [31:0] d);
    bus_req = 1; bus_we = 0; bus_addr = 12'(a);
    @(negedge clk);
    d = bus_rdata; bus_req = 0;
  endtask

  task automatic wr_desc(input int i, input logic [31:0] st, input logic [31:0] ad);
    bus_wr('h400 + 8*i, st);
    bus_wr('h400 + 8*i + 4, ad);
    m_stat[i] = st; m_addr[i] = ad;
  endtask

  function automatic logic [8:0] tx_pick(int k);
    case (k % 7)
      0: return 9'h000; 1: return 9'h0F0; 2: return 9'h100; 3: return 9'h004;
      4: return 9'h001; 5: return 9'h008; default: return 9'h002;
    endcase
  endfunction

  function automatic logic [8:0] rx_pick(int k);
    case (k % 6)
      0: return 9'h000; 1: return 9'h100; 2: return 9'h002;
      3: return 9'h080; 4: return 9'h010; default: return 9'h001;
    endcase
  endfunction

  task automatic tx_step(input logic [8:0] r);
    int p; logic [31:0] d, nw; logic irq, err;
    p = tx_p;
    chk_eq("R5 tx_req", 32'(tx_req), 1);
    chk_eq("R5 tx_len", 32'(tx_len), 32'(m_stat[p][31:16]));
    chk_eq("R5 tx_pad", 32'(tx_pad), 32'(m_stat[p][12]));
    chk_eq("R5 tx_crc", 32'(tx_crc), 32'(m_stat[p][11]));
    chk_eq("R7 tx_buf_addr", tx_buf_addr, m_addr[p]);
    tx_done = 1; tx_res = r;
    @(negedge clk);
    tx_done = 0;
    irq = m_stat[p][14]; err = |(r & 9'h10F);
    chk_eq("R8 evt_tx_frame", 32'(e_txf), 32'(irq && !err));
    chk_eq("R8 evt_tx_err", 32'(e_txe), 32'(irq && err));
    nw = {m_stat[p][31:16], 1'b0, m_stat[p][14:9], r};
    bus_rd('h400 + 8*p, d);
    chk_eq("R6 tx writeback", d, nw);
    m_stat[p] = nw;
    tx_p = (m_stat[p][13] || p == cur_cnt - 1) ? 0 : p + 1;
    bus_wr('h400 + 8*p, nw | OWN);
    m_stat[p] = nw | OWN;
  endtask

  task automatic rx_step(input logic [15:0] len, input logic [8:0] r);
    int p; logic [31:0] d, nw; logic irq, err;
    p = cur_cnt + rx_o;
    chk_eq("R9 rx_avail", 32'(rx_avail), 1);
    chk_eq("R11 rx_buf_addr", rx_buf_addr, m_addr[p]);
    rx_done = 1; rx_len = len; rx_res = r;
    @(negedge clk);
    rx_done = 0;
    irq = m_stat[p][14]; err = |r[7:0];
    chk_eq("R12 evt_rx_frame", 32'(e_rxf), 32'(irq && !err));
    chk_eq("R12 evt_rx_err", 32'(e_rxe), 32'(irq && err));
    chk_eq("R13 no busy", 32'(e_busy), 0);
    nw = {len, 1'b0, m_stat[p][14:9], r};
    bus_rd('h400 + 8*p, d);
    chk_eq("R10 rx writeback", d, nw);
    m_stat[p] = nw;
    rx_o = (m_stat[p][13] || p == NBD - 1) ? 0 : rx_o + 1;
    bus_wr('h400 + 8*p, nw | OWN);
    m_stat[p] = nw | OWN;
  endtask

  task automatic pulse_rx();
    rx_done = 1; rx_len = 16'd99; rx_res = 9'h000;
    @(negedge clk);
    rx_done = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_ni = 0; bus_req = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    tx_done = 0; tx_res = '0; rx_done = 0; rx_len = '0; rx_res = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1 reset state
    bus_rd('h00, d); chk_eq("R1 ctrl", d, 0);
    bus_rd('h20, d); chk_eq("R1 count", d, NBD/2);
    chk_eq("R1 tx_req", 32'(tx_req), 0);
    chk_eq("R1 rx_avail", 32'(rx_avail), 0);
    chk_eq("R1 events", 32'({e_txf, e_txe, e_rxf, e_rxe, e_busy}), 0);

    // R2 table map sweep
    for (int i = 0; i < NBD; i++) wr_desc(i, 32'h5A00_0000 ^ (i * 32'h0103_0207), 32'hC000_0000 + i*32'h111);
    for (int i = 0; i < NBD; i++) begin
      bus_rd('h400 + 8*i, d);     chk_eq("R2 status word", d, m_stat[i]);
      bus_rd('h400 + 8*i + 4, d); chk_eq("R2 address word", d, m_addr[i]);
    end
    for (int i = 0; i < NBD; i++) wr_desc(i, 0, 0);

    // R3 count saturation sweep
    for (int v = 0; v <= 13; v++) begin
      int wv;
      wv = (v == 13) ? 'h80 : v;
      bus_wr('h20, 32'(wv));
      bus_rd('h20, d);
      chk_eq("R3 count saturate", d, 32'((wv > NBD) ? NBD : wv));
    end

    // transmit sweep: every count, with and without a mid-ring wrap
    step_k = 0;
    for (int c = 1; c <= NBD; c++) begin
      for (int wm = 0; wm < 2; wm++) begin
        int w;
        w = wm ? c/2 : -1;
        bus_wr('h00, 0);
        bus_wr('h20, 32'(c));
        for (int i = 0; i < c; i++)
          wr_desc(i, (32'(40 + 3*i) << 16) | OWN | ((i != 1) ? IRQ : 0) | ((i == w) ? WRP : 0)
                     | ((i % 2) ? 32'h1000 : 0) | ((i % 3 == 0) ? 32'h0800 : 0) | 32'(i[1:0]) << 9,
                  32'h1000 * (i + 1) + c);
        bus_wr('h00, 2);
        tx_p = 0; cur_cnt = c;
        for (int s = 0; s < 2*c + 1; s++) begin
          tx_step(tx_pick(step_k));
          step_k++;
        end
      end
    end

    // receive sweep: every ring split, with and without a mid-ring wrap
    for (int c = 0; c < NBD; c++) begin
      for (int wm = 0; wm < 2; wm++) begin
        int w;
        w = wm ? c + (NBD - c)/2 : -1;
        bus_wr('h00, 0);
        bus_wr('h20, 32'(c));
        for (int i = c; i < NBD; i++)
          wr_desc(i, 32'hABCD_0000 | OWN | ((i != c + 1) ? IRQ : 0) | ((i == w) ? WRP : 0) | 32'(i[1:0]) << 9,
                  32'h8000 + 16*i + c);
        bus_wr('h00, 1);
        rx_o = 0; cur_cnt = c;
        for (int s = 0; s < 2*(NBD - c) + 1; s++) begin
          rx_step(16'(60 + step_k), rx_pick(step_k));
          step_k++;
        end
      end
    end

    // R4, R3, R14 on the transmit ring
    bus_wr('h00, 0);
    bus_wr('h20, 4);
    for (int i = 0; i < 4; i++) wr_desc(i, (32'(64 + i) << 16) | OWN | IRQ, 32'h2000 + i);
    bus_wr('h00, 2);
    tx_p = 0; cur_cnt = 4;
    tx_step(9'h000); tx_step(9'h000);
    bus_wr('h00, 0);
    chk_eq("R5 tx_req off when disabled", 32'(tx_req), 0);
    bus_wr('h00, 2);
    chk_eq("R4 tx pointer home after disable", tx_buf_addr, m_addr[0]);
    tx_p = 0;
    tx_step(9'h000);
    bus_wr('h20, 4);
    chk_eq("R3 tx pointer home after count write", tx_buf_addr, m_addr[0]);
    wr_desc(0, m_stat[0] & ~OWN, m_addr[0]);
    chk_eq("R5 tx_req low when not ready", 32'(tx_req), 0);
    tx_done = 1; tx_res = 9'h100;
    @(negedge clk);
    tx_done = 0;
    chk_eq("R14 no tx events", 32'({e_txf, e_txe}), 0);
    bus_rd('h400, d); chk_eq("R14 status untouched", d, m_stat[0]);
    wr_desc(0, m_stat[0] | OWN, m_addr[0]);
    chk_eq("R14 pointer unchanged", tx_buf_addr, m_addr[0]);

    // R13 busy, drop and disabled receive
    bus_wr('h00, 0);
    for (int i = 4; i < NBD; i++) wr_desc(i, ((i == 6) ? 0 : OWN) | IRQ, 32'h9000 + i);
    bus_wr('h00, 1);
    rx_o = 0; cur_cnt = 4;
    rx_step(16'd70, 9'h000); rx_step(16'd71, 9'h000);
    chk_eq("R9 rx_avail low on full descriptor", 32'(rx_avail), 0);
    pulse_rx();
    chk_eq("R13 busy event", 32'(e_busy), 1);
    chk_eq("R13 no rx frame event", 32'({e_rxf, e_rxe}), 0);
    bus_rd('h400 + 8*6, d); chk_eq("R13 dropped frame leaves table", d, m_stat[6]);
    wr_desc(6, OWN | IRQ, m_addr[6]);
    chk_eq("R13 rx_avail after rearm", 32'(rx_avail), 1);
    chk_eq("R13 pointer held on drop", rx_buf_addr, m_addr[6]);
    bus_wr('h00, 0);
    pulse_rx();
    chk_eq("R13 disabled rx quiet", 32'({e_rxf, e_rxe, e_busy}), 0);
    bus_rd('h400 + 8*6, d); chk_eq("R13 disabled rx leaves table", d, m_stat[6]);
    bus_wr('h00, 1);
    chk_eq("R4 rx pointer home after disable", rx_buf_addr, m_addr[4]);
    bus_wr('h20, NBD);
    chk_eq("R9 empty rx ring offers nothing", 32'(rx_avail), 0);
    pulse_rx();
    chk_eq("R13 busy with empty rx ring", 32'(e_busy), 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule